// File: doc/BRIEF.md
# PWM Trip Flag and Interrupt Latch

This block records protective trip events for one PWM channel and tells software about them with an interrupt. Two active-high, level-sensitive trip inputs arrive already selected and synchronised. One is a one-shot source. The other is a cycle-by-cycle source. A strobe marks the cycles in which the PWM time-base counter is at zero. Software sees a 16-bit read-only flag word. It clears flags through a write-one-to-clear strobe with a 16-bit data word.

A cycle-by-cycle trip arms an internal hold condition. That condition is released only on a counter-zero cycle in which the trip input is low. Clearing the software-visible flag does not release it. The one-shot flag is sticky. The interrupt flag gates a single-cycle interrupt pulse. Only one pulse is produced while the interrupt flag stays set. Clearing the interrupt flag while either trip flag is still set re-arms it, and a new pulse follows.

Top module: `pwm_trip_latch`

## Requirements
- R1: The flag word has the interrupt flag at bit 0, the cycle-by-cycle flag at bit 1 and the one-shot flag at bit 2. Bits 15 to 3 always read 0.
- R2: During and after reset every flag reads 0 and the interrupt output is low.
- R3: A high one-shot trip input sets the one-shot flag at the next clock edge. The flag then stays set until software clears it with bit 2 of the clear word.
- R4: While the hold condition or the cycle-by-cycle input is active, the cycle-by-cycle flag is set at every edge. A clear of bit 1 issued in that state leaves it reading 1.
- R5: The hold condition is set by a high cycle-by-cycle input. It is released only at an edge where the counter-zero strobe is high and the cycle-by-cycle input is low. After that release, a clear of bit 1 takes the flag to 0.
- R6: When the interrupt flag is 0 and a trip input is active or a trip flag is set, the interrupt flag becomes 1 at the next edge. The interrupt output is then high for exactly the one following cycle.
- R7: While the interrupt flag remains set, no further interrupt pulse is produced.
- R8: Clearing the interrupt flag (clear bit 0) while the one-shot or cycle-by-cycle flag stays set behaves as follows. The interrupt flag reads 0 for one cycle and then 1 again, and one new pulse follows.
- R9: Clears take effect only when the clear strobe is high, and only for bits written as 1. Bits 15 to 3 of the clear word are ignored. A trip on the same edge as the clear of its flag wins, and the flag stays set.
- R10: Clearing all three flags while no trip is active leaves them at 0 and produces no further interrupt until a new trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trip_ost_i | input | 1 | One-shot trip level, active high |
| trip_cbc_i | input | 1 | Cycle-by-cycle trip level, active high |
| cnt_zero_i | input | 1 | High in cycles where the time-base counter equals zero |
| clr_wr_i | input | 1 | Clear-register write strobe |
| clr_data_i | input | 16 | Clear word, write-one-to-clear per flag bit |
| flag_word_o | output | 16 | Read-only flag word |
| trip_irq_o | output | 1 | Single-cycle trip interrupt pulse |

## Verification
Two events can land on the same edge: a trip setting a flag and a software clear of that same flag. A third coincidence is a counter-zero strobe and a flag clear arriving while the cycle-by-cycle input is still high. Directed steps drive exactly these collisions: a one-shot trip with its clear, a clear of the cycle-by-cycle flag with the trip held, and a zero strobe with the trip held. Constrained random stimulus then keeps producing overlaps at chosen rates. Every cycle the flag word and interrupt pulse are judged against a cycle-level reference model built from the requirements. In that model a set always beats a clear, and the hold condition is released only on a zero cycle with the trip low.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;
  localparam int unsigned FLAG_WORD_W = 16;
  localparam int unsigned NUM_FLAGS   = 3;
  // bit positions shared by the flag word and the clear word
  localparam int unsigned INT_POS = 0;
  localparam int unsigned CBC_POS = 1;
  localparam int unsigned OST_POS = 2;
  // sticky trip flags held by the flag bank
  localparam int unsigned NUM_STICKY = 2;
  localparam int unsigned STK_CBC = 0;
  localparam int unsigned STK_OST = 1;
endpackage

// File: rtl/trip_cbc_hold.sv
module trip_cbc_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_cbc_i,
  input  logic cnt_zero_i,
  output logic cbc_active_o
);
  logic cond_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= trip_cbc_i | (cond_q & ~cnt_zero_i);
  end

  assign cbc_active_o = trip_cbc_i | cond_q;

  AST_CBC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_q && !cnt_zero_i) |=> cond_q); // R5
  AST_CBC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero_i && !trip_cbc_i) |=> !cond_q); // R5
endmodule

// File: rtl/trip_flag_bank.sv
module trip_flag_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= (flag_q[g] & ~clr_i[g]) | set_i[g];
    end

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_q[g]); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !clr_i[g]) |=> flag_q[g]); // R3
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/trip_irq_gate.sv
module trip_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pending_i,
  input  logic clr_int_i,
  output logic int_flag_o,
  output logic irq_o
);
  logic int_q, int_d1_q, irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q    <= 1'b0;
      int_d1_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      // a set flag only honours a clear; a clear flag only looks at pending work
      int_q    <= int_q ? ~clr_int_i : pending_i;
      int_d1_q <= int_q;
      irq_q    <= int_q & ~int_d1_q;
    end
  end

  assign int_flag_o = int_q;
  assign irq_o      = irq_q;

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R6
  AST_IRQ_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_q) |=> irq_q); // R6
  AST_NO_REPULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q && $past(int_q)) |=> !irq_q); // R7
endmodule

// File: rtl/pwm_trip_latch.sv
module pwm_trip_latch
  import pwm_trip_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trip_ost_i,
  input  logic                   trip_cbc_i,
  input  logic                   cnt_zero_i,
  input  logic                   clr_wr_i,
  input  logic [FLAG_WORD_W-1:0] clr_data_i,
  output logic [FLAG_WORD_W-1:0] flag_word_o,
  output logic                   trip_irq_o
);
  logic                  cbc_active;
  logic [NUM_FLAGS-1:0]  clr_vec;
  logic [NUM_STICKY-1:0] stk_set, stk_clr, stk_flag;
  logic                  int_flag, pending;
  logic                  unused_clr_hi;

  assign clr_vec       = clr_wr_i ? clr_data_i[NUM_FLAGS-1:0] : '0;
  assign unused_clr_hi = ^clr_data_i[FLAG_WORD_W-1:NUM_FLAGS];

  trip_cbc_hold u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .trip_cbc_i   (trip_cbc_i),
    .cnt_zero_i   (cnt_zero_i),
    .cbc_active_o (cbc_active)
  );

  always_comb begin
    stk_set          = '0;
    stk_clr          = '0;
    stk_set[STK_CBC] = cbc_active;
    stk_set[STK_OST] = trip_ost_i;
    stk_clr[STK_CBC] = clr_vec[CBC_POS];
    stk_clr[STK_OST] = clr_vec[OST_POS];
  end

  trip_flag_bank #(.N(NUM_STICKY)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (stk_set),
    .clr_i  (stk_clr),
    .flag_o (stk_flag)
  );

  assign pending = (|stk_flag) | (|stk_set);

  trip_irq_gate u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pending_i  (pending),
    .clr_int_i  (clr_vec[INT_POS]),
    .int_flag_o (int_flag),
    .irq_o      (trip_irq_o)
  );

  always_comb begin
    flag_word_o          = '0;
    flag_word_o[INT_POS] = int_flag;
    flag_word_o[CBC_POS] = stk_flag[STK_CBC];
    flag_word_o[OST_POS] = stk_flag[STK_OST];
  end

  AST_CBC_REFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cbc_active |=> flag_word_o[CBC_POS]); // R4
  AST_INT_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_word_o[INT_POS] && clr_vec[INT_POS] &&
     ((flag_word_o[OST_POS] && !clr_vec[OST_POS]) ||
      (flag_word_o[CBC_POS] && !clr_vec[CBC_POS]))) |=> ##1 flag_word_o[INT_POS]); // R8
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> (flag_word_o == '0 && !trip_irq_o)); // R2
endmodule

// File: tb/pwm_trip_latch_bench.sv
module pwm_trip_latch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trip_ost_i = 1'b0, trip_cbc_i = 1'b0, cnt_zero_i = 1'b0, clr_wr_i = 1'b0;
  logic [15:0] clr_data_i = '0;
  logic [15:0] flag_word_o;
  logic        trip_irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pwm_trip_latch u_pwm_trip_latch (
    .clk(clk), .rst_n(rst_n), .trip_ost_i(trip_ost_i), .trip_cbc_i(trip_cbc_i),
    .cnt_zero_i(cnt_zero_i), .clr_wr_i(clr_wr_i), .clr_data_i(clr_data_i),
    .flag_word_o(flag_word_o), .trip_irq_o(trip_irq_o)
  );

  typedef struct packed {
    logic cond, cbc, ost, intf, intp, irq;
  } mst_t;

  mst_t m = '0;

  function automatic mst_t model_next(mst_t s, logic o, logic c, logic z, logic w, logic [15:0] d);
    mst_t n;
    logic [2:0] cl;
    logic cact;
    cl     = w ? d[2:0] : 3'b000;
    cact   = c | s.cond;
    n.cond = c | (s.cond & ~z);
    n.cbc  = (s.cbc & ~cl[1]) | cact;
    n.ost  = (s.ost & ~cl[2]) | o;
    n.intf = s.intf ? ~cl[0] : (s.ost | s.cbc | o | cact);
    n.intp = s.intf;
    n.irq  = s.intf & ~s.intp;
    return n;
  endfunction

  function automatic logic [15:0] model_word(mst_t s);
    return {13'b0, s.ost, s.cbc, s.intf};
  endfunction

  task automatic compare(string tag);
    n_vec++;
    if (flag_word_o !== model_word(m)) begin
      n_bad++;
      $display("FAIL %s/R1 flag word actual=%h expected=%h", tag, flag_word_o, model_word(m));
    end
    n_vec++;
    if (trip_irq_o !== m.irq) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, trip_irq_o, m.irq);
    end
  endtask

  task automatic check_lit(logic [15:0] ew, logic ei, string tag);
    n_vec++;
    if (flag_word_o !== ew || trip_irq_o !== ei) begin
      n_bad++;
      $display("FAIL %s actual=%h/%b expected=%h/%b", tag, flag_word_o, trip_irq_o, ew, ei);
    end
  endtask

  task automatic step(logic o, logic c, logic z, logic w, logic [15:0] d, string tag);
    trip_ost_i = o; trip_cbc_i = c; cnt_zero_i = z; clr_wr_i = w; clr_data_i = d;
    m = model_next(m, o, c, z, w, d);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(20 * 50000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4271));
    repeat (3) @(negedge clk);
    check_lit(16'h0000, 1'b0, "R2 in reset");
    rst_n = 1'b1;
    m = '0;
    @(negedge clk);
    compare("R2");
    check_lit(16'h0000, 1'b0, "R2 after reset");

    // cycle-by-cycle trip and interrupt pulse
    step(0, 1, 0, 0, 16'h0000, "R6");  check_lit(16'h0003, 1'b0, "R6 flag rise");
    step(0, 0, 0, 0, 16'h0000, "R6");  check_lit(16'h0003, 1'b1, "R6 pulse");
    step(0, 0, 0, 0, 16'h0000, "R7");  check_lit(16'h0003, 1'b0, "R7 single pulse");
    step(0, 0, 0, 1, 16'h0002, "R4");  check_lit(16'h0003, 1'b0, "R4 held by condition");
    step(0, 0, 1, 0, 16'h0000, "R5");  check_lit(16'h0003, 1'b0, "R5 zero release");
    step(0, 0, 0, 1, 16'h0002, "R5");  check_lit(16'h0001, 1'b0, "R5 clear after release");
    // one-shot while interrupt set, then re-arm
    step(1, 0, 0, 0, 16'h0000, "R3");  check_lit(16'h0005, 1'b0, "R3 one-shot set");
    step(0, 0, 0, 0, 16'h0000, "R7");  check_lit(16'h0005, 1'b0, "R7 no pulse");
    step(0, 0, 0, 1, 16'h0001, "R8");  check_lit(16'h0004, 1'b0, "R8 int cleared");
    step(0, 0, 0, 0, 16'h0000, "R8");  check_lit(16'h0005, 1'b0, "R8 int re-set");
    step(0, 0, 0, 0, 16'h0000, "R8");  check_lit(16'h0005, 1'b1, "R8 new pulse");
    step(0, 0, 0, 1, 16'h0007, "R10"); check_lit(16'h0000, 1'b0, "R10 all cleared");
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 0, 0, 16'h0000, "R10"); check_lit(16'h0000, 1'b0, "R10 quiet");
    end
    // set against clear collisions and ignored writes
    step(1, 0, 0, 1, 16'h0004, "R9");  check_lit(16'h0005, 1'b0, "R9 set beats clear");
    step(0, 0, 0, 0, 16'h0007, "R9");  check_lit(16'h0005, 1'b1, "R9 strobe low ignored");
    step(0, 0, 0, 1, 16'hFFF8, "R9");  check_lit(16'h0005, 1'b0, "R9 upper bits ignored");
    step(0, 0, 0, 1, 16'h0007, "R10"); check_lit(16'h0000, 1'b0, "R10 cleared");
    // trip held across zero and clears
    step(0, 1, 0, 0, 16'h0000, "R4");  check_lit(16'h0003, 1'b0, "R4 set");
    step(0, 1, 1, 1, 16'h0002, "R4");  check_lit(16'h0003, 1'b1, "R4 held trip re-sets");
    step(0, 0, 0, 1, 16'h0002, "R5");  check_lit(16'h0003, 1'b0, "R5 no release off zero");
    step(0, 0, 1, 0, 16'h0000, "R5");
    step(0, 0, 0, 1, 16'h0007, "R10"); check_lit(16'h0000, 1'b0, "R10 final clear");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic o, c, z, w;
      logic [15:0] d;
      o = ($urandom_range(15) == 0);
      c = ($urandom_range(5) == 0);
      z = ($urandom_range(7) == 0);
      w = ($urandom_range(3) == 0);
      d = 16'($urandom);
      if ($urandom_range(1) == 0) d[15:3] = '0;
      step(o, c, z, w, d, "R3/R4/R5/R6/R8/R9 random");
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule